// File: doc/BRIEF.md
# Flow-Through Synchronous Burst Static RAM

This block is a single-port synchronous static RAM meant to hold cache line data. Each word is 36 bits, split into four 9-bit byte lanes. Address, write data, chip enable, both address strobes, the burst-advance input and all write controls are captured on the rising clock edge. The output enable and the burst-order select act without a clock.

A burst begins when either address strobe is asserted with the chip enabled. One strobe belongs to the processor side and the other to the cache controller. The strobe loads the external address, and a 2-bit counter then steps the two low address bits on each cycle that asks for an advance. The steps follow either a linear order or an interleaved order. Read data is not registered on the way out: the word at the registered address reaches the output in the same cycle, so a word written at an edge can be read back right after that edge.

The address width is a parameter. The default builds a 2048-word array so that the default elaboration stays small. Setting `ADDR_W` to 15 gives the full 32K-word store.

Top module: `fts_burst_ram`

## Requirements
- R1: After reset the block is deselected, and `data_out` is all zeros even with `oe` high.
- R2: A cycle with `chip_en` high and either strobe high loads `addr_in` into the address register and resets the burst counter. The word at that address appears on `data_out` in that same cycle, with no output register.
- R3: While `burst_linear` is 1, the low two address bits equal (start + count) mod 4. A change of `burst_linear` alters `data_out` without any clock edge.
- R4: While `burst_linear` is 0, the low two address bits equal start XOR count.
- R5: The counter moves forward by one, wrapping after 4, only on non-strobe cycles with `adv` high while selected. A write on such a cycle goes to the advanced address. With `adv` low the address holds.
- R6: Lane k occupies bits 9k+8 down to 9k (lane a = bits 8:0, up to lane d = bits 35:27). Lane k is written only when `byte_we[k]` and `wr_en` are both high. Every other lane keeps its old value, and `wr_en` low with no global write changes nothing.
- R7: `glob_wr` high writes all four lanes, whatever the states of `wr_en` and `byte_we`.
- R8: A cycle started by `strobe_proc` ignores every write control and only reads.
- R9: When both strobes are high, `strobe_proc` takes priority, so the cycle loads the address and reads.
- R10: With `oe` low, `data_out` is all zeros at once, without a clock edge.
- R11: A strobe with `chip_en` low deselects the block. `data_out` then reads zero and no write occurs, even on later non-strobe cycles, until the next enabled strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | Word address, taken when a strobe is accepted |
| data_in | input | 36 | Write data |
| chip_en | input | 1 | Chip enable, qualifies both strobes |
| strobe_proc | input | 1 | Processor-side address strobe, starts a read burst |
| strobe_ctrl | input | 1 | Controller-side address strobe, starts a read or write burst |
| adv | input | 1 | Burst advance request |
| wr_en | input | 1 | Write enable for the per-lane writes |
| glob_wr | input | 1 | Write all lanes |
| byte_we | input | 4 | Per-lane write selects, bit k for lane k |
| oe | input | 1 | Asynchronous output enable |
| burst_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| data_out | output | 36 | Flow-through read data, zero when disabled or deselected |

## Verification
The bench builds the block with `ADDR_W` = 6, giving a 64-word array while keeping four 9-bit lanes. At that size the bench writes and reads back every word. It runs full bursts from all four start offsets in both orders, including the wrap back to the start. It also applies all sixteen lane-select masks to one word, and every result is checked against a reference memory held in the bench.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;

  // Kind of cycle decoded from the strobes and chip enable
  typedef enum logic [1:0] {
    START_NONE  = 2'd0,
    START_PROC  = 2'd1,
    START_CTRL  = 2'd2,
    START_DESEL = 2'd3
  } start_kind_t;

  // Low two address bits for a given start offset and burst count
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       linear);
    logic [1:0] r;
    if (linear) r = start + cnt;
    else        r = start ^ cnt;
    return r;
  endfunction

  // Lane write mask from the write controls
  function automatic logic [3:0] lane_mask(input logic       glob,
                                           input logic       wen,
                                           input logic [3:0] sel);
    logic [3:0] r;
    if (glob)     r = 4'hF;
    else if (wen) r = sel;
    else          r = 4'h0;
    return r;
  endfunction

endpackage

// File: rtl/fts_addr_ctrl.sv
`timescale 1ns/1ps
module fts_addr_ctrl
  import fts_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  start_kind_t       kind,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              adv,
  input  logic              linear,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              sel_q,
  output logic              sel_nxt
);

  logic [ADDR_W-1:0] base_q, base_n;
  logic [1:0]        cnt_q, cnt_n;
  logic              step_evt;

  assign step_evt = (kind == START_NONE) && adv && sel_q;

  always_comb begin
    base_n  = base_q;
    cnt_n   = cnt_q;
    sel_nxt = sel_q;
    case (kind)
      START_PROC, START_CTRL: begin
        base_n  = addr_in;
        cnt_n   = 2'd0;
        sel_nxt = 1'b1;
      end
      START_DESEL: sel_nxt = 1'b0;
      default: if (step_evt) cnt_n = cnt_q + 2'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
      sel_q  <= sel_nxt;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, linear)};
  assign nxt_addr = {base_n[ADDR_W-1:2], burst_low(base_n[1:0], cnt_n, linear)};

  assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
    (kind == START_PROC || kind == START_CTRL) |=>
      (base_q == $past(addr_in) && cnt_q == 2'd0 && sel_q));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (kind == START_NONE && !adv) |=> ($stable(cnt_q) && $stable(base_q)));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (kind == START_NONE && adv && sel_q) |=> (cnt_q == $past(cnt_q) + 2'd1));

  assert_desel_R11: assert property (@(posedge clk) disable iff (rst)
    (kind == START_DESEL) |=> !sel_q);

endmodule

// File: rtl/fts_lane_ctrl.sv
`timescale 1ns/1ps
module fts_lane_ctrl
  import fts_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             allow,
  input  logic             glob,
  input  logic             wen,
  input  logic [LANES-1:0] sel,
  output logic [LANES-1:0] lane_we
);

  logic [3:0] mask;

  assign mask    = lane_mask(glob, wen, 4'(sel));
  assign lane_we = allow ? mask[LANES-1:0] : '0;

  assert_global_R7: assert property (@(posedge clk) disable iff (rst)
    (allow && glob) |-> (&lane_we));

  assert_lane_only_R6: assert property (@(posedge clk) disable iff (rst)
    (!glob) |-> ((lane_we & ~sel) == '0 && (wen || lane_we == '0)));

endmodule

// File: rtl/fts_array.sv
`timescale 1ns/1ps
module fts_array #(
  parameter int ADDR_W = 11,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/fts_burst_ram.sv
`timescale 1ns/1ps
module fts_burst_ram
  import fts_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic [LANES*LANE_W-1:0] data_in,
  input  logic                    chip_en,
  input  logic                    strobe_proc,
  input  logic                    strobe_ctrl,
  input  logic                    adv,
  input  logic                    wr_en,
  input  logic                    glob_wr,
  input  logic [LANES-1:0]        byte_we,
  input  logic                    oe,
  input  logic                    burst_linear,
  output logic [LANES*LANE_W-1:0] data_out
);

  localparam int WORD_W = LANES * LANE_W;

  start_kind_t       kind;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic              sel_q, sel_nxt, wr_allow;
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] rd_word;

  always_comb begin
    if (!(strobe_proc || strobe_ctrl)) kind = START_NONE;
    else if (!chip_en)                 kind = START_DESEL;
    else if (strobe_proc)              kind = START_PROC;
    else                               kind = START_CTRL;
  end

  assign wr_allow = !rst && sel_nxt && (kind != START_PROC);

  fts_addr_ctrl #(.ADDR_W(ADDR_W)) addr_i (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .addr_in  (addr_in),
    .adv      (adv),
    .linear   (burst_linear),
    .cur_addr (cur_addr),
    .nxt_addr (nxt_addr),
    .sel_q    (sel_q),
    .sel_nxt  (sel_nxt)
  );

  fts_lane_ctrl #(.LANES(LANES)) lane_i (
    .clk     (clk),
    .rst     (rst),
    .allow   (wr_allow),
    .glob    (glob_wr),
    .wen     (wr_en),
    .sel     (byte_we),
    .lane_we (lane_we)
  );

  fts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk     (clk),
    .lane_we (lane_we),
    .wr_addr (nxt_addr),
    .wr_data (data_in),
    .rd_addr (cur_addr),
    .rd_data (rd_word)
  );

  assign data_out = (oe && sel_q) ? rd_word : '0;

  // Processor-strobe cycles, including both strobes together, never write
  assert_proc_read_R8: assert property (@(posedge clk) disable iff (rst)
    (chip_en && strobe_proc) |-> (lane_we == '0));

  assert_desel_nowrite_R11: assert property (@(posedge clk) disable iff (rst)
    (!chip_en && (strobe_proc || strobe_ctrl)) |-> (lane_we == '0));

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (data_out == '0));

  always_comb begin
    if (!oe) assert_oe_off_R10: assert (data_out == '0);
  end

endmodule

// File: tb/fts_burst_ram_tb.sv
`timescale 1ns/1ps
module fts_burst_ram_tb_top;

  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_in;
  logic [35:0]   data_in;
  logic          chip_en, strobe_proc, strobe_ctrl, adv, wr_en, glob_wr;
  logic [3:0]    byte_we;
  logic          oe, burst_linear;
  logic [35:0]   data_out;

  logic [35:0]   model [DEPTH];
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  fts_burst_ram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .addr_in(addr_in), .data_in(data_in),
    .chip_en(chip_en), .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl),
    .adv(adv), .wr_en(wr_en), .glob_wr(glob_wr), .byte_we(byte_we),
    .oe(oe), .burst_linear(burst_linear), .data_out(data_out)
  );

  function automatic logic [35:0] pat(input int a, input int salt);
    return 36'(a * 32'h00A5_3C91 + salt * 32'h0013_7F01 + 7);
  endfunction

  function automatic logic [1:0] low_of(input int s, input int k, input bit lin);
    return lin ? 2'((s + k) % 4) : 2'(s ^ (k % 4));
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    chip_en = 1; strobe_proc = 0; strobe_ctrl = 0; adv = 0;
    wr_en = 0; glob_wr = 0; byte_we = 4'h0;
  endtask

  // one clock: inputs set before, sample at the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    quiet();
  endtask

  task automatic model_wr(input int a, input logic [3:0] m, input logic [35:0] d);
    for (int l = 0; l < 4; l++)
      if (m[l]) model[a][9*l +: 9] = d[9*l +: 9];
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    quiet(); oe = 1; burst_linear = 1; addr_in = '0; data_in = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset deselected", data_out, 36'h0);
    step();
    check("R1 idle after reset", data_out, 36'h0);

    // Fill every word with global writes via controller strobe (R7, R2)
    for (int a = 0; a < DEPTH; a++) begin
      strobe_ctrl = 1; addr_in = AW'(a); glob_wr = 1; data_in = pat(a, 0);
      model[a] = pat(a, 0);
      step();
      check("R2/R7 write-through readout", data_out, model[a]);
    end
    // Read every word back via processor strobe (R2)
    for (int a = 0; a < DEPTH; a++) begin
      strobe_proc = 1; addr_in = AW'(a);
      step();
      check("R2 flow-through read", data_out, model[a]);
    end

    // Bursts in both orders from every start offset (R3, R4, R5)
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 4; s++) begin
        int hi;
        hi = 4 + lin * 6 + s;
        burst_linear = lin[0];
        strobe_proc = 1; addr_in = AW'(hi * 4 + s);
        step();
        check(lin ? "R3 burst k0" : "R4 burst k0", data_out, model[hi*4 + s]);
        for (int k = 1; k <= 4; k++) begin
          adv = 1;
          step();
          check(lin ? "R3 linear step" : "R4 interleaved step", data_out,
                model[hi*4 + int'(low_of(s, k, lin[0]))]);
          if (k == 1) begin
            burst_linear = ~lin[0];
            #0.5;
            check("R3 async order select", data_out,
                  model[hi*4 + int'(low_of(s, k, ~lin[0]))]);
            burst_linear = lin[0];
            #0.5;
          end
        end
        step();
        check("R5 hold without advance", data_out,
              model[hi*4 + int'(low_of(s, 4, lin[0]))]);
      end
    end
    burst_linear = 1;

    // All lane masks on one word (R6)
    for (int m = 0; m < 16; m++) begin
      strobe_ctrl = 1; addr_in = AW'(5); wr_en = 1; byte_we = 4'(m);
      data_in = pat(m, 9);
      model_wr(5, 4'(m), pat(m, 9));
      step();
      check("R6 lane write mask", data_out, model[5]);
    end
    strobe_ctrl = 1; addr_in = AW'(5); wr_en = 0; byte_we = 4'hF; data_in = 36'hF_FFFF_FFFF;
    step();
    check("R6 write enable low no change", data_out, model[5]);

    // Global write overrides absent wr_en / byte_we (R7)
    strobe_ctrl = 1; addr_in = AW'(6); glob_wr = 1; wr_en = 0; byte_we = 4'h0;
    data_in = 36'h1_2345_6789; model[6] = 36'h1_2345_6789;
    step();
    check("R7 global write", data_out, model[6]);

    // Processor strobe ignores write controls (R8) and wins over controller (R9)
    strobe_proc = 1; addr_in = AW'(7); glob_wr = 1; wr_en = 1; byte_we = 4'hF;
    data_in = 36'hA_AAAA_AAAA;
    step();
    check("R8 proc strobe no write", data_out, model[7]);
    strobe_proc = 1; strobe_ctrl = 1; addr_in = AW'(8); glob_wr = 1;
    data_in = 36'h5_5555_5555;
    step();
    check("R9 proc priority read", data_out, model[8]);
    strobe_proc = 1; addr_in = AW'(8);
    step();
    check("R9 no write stored", data_out, model[8]);

    // Burst write: start on controller, continue with advance (R5, R7)
    strobe_ctrl = 1; addr_in = AW'(20); glob_wr = 1; data_in = pat(20, 3);
    model[20] = pat(20, 3);
    step();
    check("R5 burst write start", data_out, model[20]);
    for (int k = 1; k < 4; k++) begin
      adv = 1; glob_wr = 1; data_in = pat(20 + k, 3);
      model[20 + k] = pat(20 + k, 3);
      step();
      check("R5 burst write advanced", data_out, model[20 + k]);
    end
    for (int k = 0; k < 4; k++) begin
      strobe_proc = 1; addr_in = AW'(20 + k);
      step();
      check("R5 burst write readback", data_out, model[20 + k]);
    end

    // Output enable (R10)
    oe = 0; #0.5;
    check("R10 oe low zero", data_out, 36'h0);
    oe = 1; #0.5;
    check("R10 oe high restores", data_out, model[23]);

    // Deselect (R11)
    chip_en = 0; strobe_ctrl = 1; addr_in = AW'(30); glob_wr = 1; data_in = 36'h0_DEAD_BEEF;
    step();
    check("R11 deselected output", data_out, 36'h0);
    adv = 1; glob_wr = 1; data_in = 36'h0_FEED_FACE;
    step();
    check("R11 still deselected", data_out, 36'h0);
    strobe_proc = 1; addr_in = AW'(23);
    step();
    check("R11 no write while deselected", data_out, model[23]);
    strobe_proc = 1; addr_in = AW'(30);
    step();
    check("R11 strobe address not written", data_out, model[30]);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule